// File: doc/BRIEF.md
# Super-IO Configuration Port with System-Bus Bridge

This block is a byte-wide configuration space that a host reaches with simple I/O cycles through two ports: an index port, which selects a configuration register, and a data port, which reads or writes the selected register. The space stays locked until the host writes a password byte to the index port twice in a row. A device-select register in the global area picks which logical-device bank the upper indices reach.

One logical device is a bridge to a 32-bit system bus. The host loads a target address, four data bytes and a length code into the bridge registers. It then touches a trigger index through the data port. A data-port read of the trigger starts a bus read, and a data-port write starts a bus write. Only one bus transaction can be outstanding at a time. The result of a read lands back in the bridge data bytes, where the host collects it one byte at a time. The other logical devices are small scratch banks.

Top module: `cfgPortBridge`

## Requirements
- R1: After reset the space is locked, the latched index and the selected device are 0x00, all bridge and scratch registers are 0x00, busReq is low and busLen is 1.
- R2: The space unlocks when 0xA5 is written to port 0x2E on two consecutive index-port writes. Any other value written to 0x2E while locked restarts the count. Data-port cycles do not affect the count.
- R3: While locked, writes to port 0x2F are ignored, and reads of port 0x2F or 0x2E return 0xFF. Index-port writes other than the password do not change the latched index.
- R4: While unlocked, writing 0xAA to port 0x2E locks the space again, and two further 0xA5 writes are then needed to unlock it.
- R5: While unlocked, a write to port 0x2E latches the index, and a read of 0x2E returns it. ioRdata is combinational and valid in the same cycle as ioRd. Reads of any port other than 0x2E or 0x2F return 0xFF.
- R6: Global index 0x07 holds the device select and can be read back. Indices below 0x30 are global whatever device is selected. The other global indices read 0x00 and ignore writes.
- R7: Devices 0 to 3 each own 4 scratch bytes at indices 0x30 and above, selected by the two low index bits, and each device's bytes are kept separate. A device that is neither 0 to 3 nor the bridge reads 0xFF and ignores writes.
- R8: In device 0x0D, indices 0xF0 to 0xF3 hold busAddr, with 0xF0 as the most significant byte. Indices 0xF4 to 0xF7 hold busWdata, with 0xF4 as the most significant byte. All of these can be read back.
- R9: Bridge index 0xF8 holds the length code. busLen is 1 for code 0, 2 for code 1 and 4 for any other code.
- R10: A data-port read of bridge index 0xFE while idle raises busReq with busWe low at the next clock edge. That read returns 0x00, and reading 0xFE returns 0x01 while a transaction is outstanding.
- R11: A data-port write of bridge index 0xFE while idle raises busReq with busWe high at the next clock edge.
- R12: busReq stays high until a cycle with busReady high, and it is low from the next cycle on. When a read completes, busRdata is stored into the data bytes, with the most significant byte at 0xF4.
- R13: While busReq is high, further triggers are ignored and writes to bridge indices 0xF0 to 0xF8 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 8 | Host I/O port address |
| ioRd | input | 1 | Host read strobe, one cycle |
| ioWr | input | 1 | Host write strobe, one cycle |
| ioWdata | input | 8 | Host write data |
| ioRdata | output | 8 | Host read data, combinational |
| busReq | output | 1 | Bus request, held until ready |
| busWe | output | 1 | Bus direction, 1 = write |
| busAddr | output | 32 | Bus target address |
| busWdata | output | 32 | Bus write data (bridge data bytes) |
| busLen | output | 3 | Transfer size in bytes (1, 2 or 4) |
| busReady | input | 1 | Bus completion |
| busRdata | input | 32 | Bus read result, valid with busReady |

## Verification
The unlock logic is driven with a password pair that is broken by another index value, with a clean pair, and with a relock followed by a second unlock. This shows that only consecutive password writes count. Register traffic is sent to the global area, to two scratch devices and to an unpopulated device, which separates global decoding from device banking. Bridge transactions are run as writes and reads with short, zero and long bus latencies. During the long-latency write, retriggers and register writes are injected to show that the outstanding transfer and its operands are left alone. A behavioural model in the bench shadows all of these patterns and is compared on every clock.

// File: rtl/cfgPortPkg.sv
package cfgPortPkg;
  localparam logic [7:0] INDEX_PORT   = 8'h2E;
  localparam logic [7:0] DATA_PORT    = 8'h2F;
  localparam logic [7:0] LOCK_CODE    = 8'hAA;
  localparam logic [7:0] DEVSEL_IDX   = 8'h07;
  localparam logic [7:0] GLOBAL_LIMIT = 8'h30;
  localparam logic [7:0] BRG_BASE     = 8'hF0;
  localparam logic [7:0] LEN_IDX      = 8'hF8;
  localparam logic [7:0] TRIG_IDX     = 8'hFE;

  typedef struct packed {
    logic scrWr;
    logic brgWr;
    logic launchRd;
    logic launchWr;
  } cfgStrobeT;
endpackage

// File: rtl/cfgPortCtrl.sv
module cfgPortCtrl
  import cfgPortPkg::*;
#(
  parameter logic [7:0] PASSWORD    = 8'hA5,
  parameter logic [7:0] BRIDGE_DEV  = 8'h0D,
  parameter int         NUM_SCR_DEV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] ioAddr,
  input  logic       ioRd,
  input  logic       ioWr,
  input  logic [7:0] ioWdata,
  input  logic       busy,
  input  logic [7:0] devData,
  output logic [7:0] idx,
  output logic [7:0] dev,
  output cfgStrobeT  strb,
  output logic [7:0] ioRdata
);
  logic       unlocked;
  logic       pwSeen;
  logic [7:0] idxQ;
  logic [7:0] devQ;
  logic       idxWr, dataWr, dataRd;
  logic       isGlobal, inBridge;

  assign idxWr    = ioWr && (ioAddr == INDEX_PORT);
  assign dataWr   = ioWr && (ioAddr == DATA_PORT) && unlocked;
  assign dataRd   = ioRd && (ioAddr == DATA_PORT) && unlocked;
  assign isGlobal = idxQ < GLOBAL_LIMIT;
  assign inBridge = !isGlobal && (devQ == BRIDGE_DEV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlocked <= 1'b0;
      pwSeen   <= 1'b0;
      idxQ     <= 8'h00;
      devQ     <= 8'h00;
    end else begin
      if (idxWr) begin
        if (!unlocked) begin
          if (ioWdata == PASSWORD) begin
            unlocked <= pwSeen;
            pwSeen   <= !pwSeen;
          end else begin
            pwSeen <= 1'b0;
          end
        end else if (ioWdata == LOCK_CODE) begin
          unlocked <= 1'b0;
          pwSeen   <= 1'b0;
        end else begin
          idxQ <= ioWdata;
        end
      end
      if (dataWr && (idxQ == DEVSEL_IDX)) devQ <= ioWdata;
    end
  end

  always_comb begin
    strb.scrWr    = dataWr && !isGlobal && (devQ != BRIDGE_DEV) && (int'(devQ) < NUM_SCR_DEV);
    strb.brgWr    = dataWr && inBridge && (idxQ != TRIG_IDX) && !busy;
    strb.launchRd = dataRd && inBridge && (idxQ == TRIG_IDX) && !busy;
    strb.launchWr = dataWr && inBridge && (idxQ == TRIG_IDX) && !busy;
  end

  always_comb begin
    ioRdata = 8'hFF;
    if (unlocked) begin
      if (ioAddr == INDEX_PORT) ioRdata = idxQ;
      else if (ioAddr == DATA_PORT) begin
        if (isGlobal) ioRdata = (idxQ == DEVSEL_IDX) ? devQ : 8'h00;
        else          ioRdata = devData;
      end
    end
  end

  assign idx = idxQ;
  assign dev = devQ;

  AST_UNLOCK_NEEDS_PW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(idxWr && (ioWdata == PASSWORD))); // R2
  AST_RELOCK: assert property (@(posedge clk) disable iff (!rstN)
    unlocked && idxWr && (ioWdata == LOCK_CODE) |=> !unlocked); // R4
  AST_LOCKED_IDX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> $stable(idxQ)); // R3
endmodule

// File: rtl/cfgPortRegs.sv
module cfgPortRegs
  import cfgPortPkg::*;
#(
  parameter logic [7:0] BRIDGE_DEV  = 8'h0D,
  parameter int         NUM_SCR_DEV = 4,
  parameter int         SCR_DEPTH   = 4,
  parameter int         BUS_AW      = 32,
  parameter int         BUS_DW      = 32,
  localparam int        DATA_BYTES  = BUS_DW / 8,
  localparam int        LENW        = $clog2(DATA_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobeT         strb,
  input  logic [7:0]        idx,
  input  logic [7:0]        dev,
  input  logic [7:0]        wdata,
  input  logic              busReady,
  input  logic [BUS_DW-1:0] busRdata,
  output logic              busReq,
  output logic              busWe,
  output logic [BUS_AW-1:0] busAddr,
  output logic [BUS_DW-1:0] busWdata,
  output logic [LENW-1:0]   busLen,
  output logic [7:0]        devData
);
  localparam int ADDR_BYTES = BUS_AW / 8;
  localparam int DATA_BASE  = int'(BRG_BASE) + ADDR_BYTES;
  localparam int DEVW       = $clog2(NUM_SCR_DEV);
  localparam int SCRW       = $clog2(SCR_DEPTH);
  localparam int SCR_TOTAL  = NUM_SCR_DEV * SCR_DEPTH;

  logic [7:0]        scr [SCR_TOTAL];
  logic [BUS_AW-1:0] addrReg;
  logic [BUS_DW-1:0] dataReg;
  logic [7:0]        lenCode;
  logic [DEVW+SCRW-1:0] scrPtr;

  assign scrPtr = {dev[DEVW-1:0], idx[SCRW-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SCR_TOTAL; i++) scr[i] <= 8'h00;
    end else if (strb.scrWr) begin
      scr[scrPtr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      lenCode <= 8'h00;
      busReq  <= 1'b0;
      busWe   <= 1'b0;
    end else begin
      if (strb.brgWr) begin
        for (int k = 0; k < ADDR_BYTES; k++)
          if (int'(idx) == int'(BRG_BASE) + k) addrReg[(ADDR_BYTES-1-k)*8 +: 8] <= wdata;
        for (int k = 0; k < DATA_BYTES; k++)
          if (int'(idx) == DATA_BASE + k) dataReg[(DATA_BYTES-1-k)*8 +: 8] <= wdata;
        if (idx == LEN_IDX) lenCode <= wdata;
      end
      if (strb.launchRd || strb.launchWr) begin
        busReq <= 1'b1;
        busWe  <= strb.launchWr;
      end else if (busReq && busReady) begin
        busReq <= 1'b0;
        if (!busWe) dataReg <= busRdata;
      end
    end
  end

  always_comb begin
    case (lenCode)
      8'd0:    busLen = LENW'(1);
      8'd1:    busLen = LENW'(2);
      default: busLen = LENW'(DATA_BYTES);
    endcase
  end

  always_comb begin
    devData = 8'h00;
    if (dev == BRIDGE_DEV) begin
      for (int k = 0; k < ADDR_BYTES; k++)
        if (int'(idx) == int'(BRG_BASE) + k) devData = addrReg[(ADDR_BYTES-1-k)*8 +: 8];
      for (int k = 0; k < DATA_BYTES; k++)
        if (int'(idx) == DATA_BASE + k) devData = dataReg[(DATA_BYTES-1-k)*8 +: 8];
      if (idx == LEN_IDX)  devData = lenCode;
      if (idx == TRIG_IDX) devData = {7'b0, busReq};
    end else if (int'(dev) < NUM_SCR_DEV) begin
      devData = scr[scrPtr];
    end else begin
      devData = 8'hFF;
    end
  end

  assign busAddr  = addrReg;
  assign busWdata = dataReg;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busReady |=> busReq); // R12
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busReady |=> !busReq); // R12
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busReady && !busWe |=> busWdata == $past(busRdata)); // R12
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busReady |=> $stable(busAddr) && $stable(busWdata) && $stable(busWe) && $stable(busLen)); // R13
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !(strb.launchRd || strb.launchWr)); // R13
endmodule

// File: rtl/cfgPortBridge.sv
module cfgPortBridge
  import cfgPortPkg::*;
#(
  parameter logic [7:0] PASSWORD    = 8'hA5,
  parameter logic [7:0] BRIDGE_DEV  = 8'h0D,
  parameter int         NUM_SCR_DEV = 4,
  parameter int         SCR_DEPTH   = 4,
  parameter int         BUS_AW      = 32,
  parameter int         BUS_DW      = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [7:0]                  ioAddr,
  input  logic                        ioRd,
  input  logic                        ioWr,
  input  logic [7:0]                  ioWdata,
  output logic [7:0]                  ioRdata,
  output logic                        busReq,
  output logic                        busWe,
  output logic [BUS_AW-1:0]           busAddr,
  output logic [BUS_DW-1:0]           busWdata,
  output logic [$clog2(BUS_DW/8):0]   busLen,
  input  logic                        busReady,
  input  logic [BUS_DW-1:0]           busRdata
);
  cfgStrobeT  strb;
  logic [7:0] idx, dev, devData;

  cfgPortCtrl #(
    .PASSWORD(PASSWORD), .BRIDGE_DEV(BRIDGE_DEV), .NUM_SCR_DEV(NUM_SCR_DEV)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioWdata(ioWdata), .busy(busReq), .devData(devData), .idx(idx),
    .dev(dev), .strb(strb), .ioRdata(ioRdata)
  );

  cfgPortRegs #(
    .BRIDGE_DEV(BRIDGE_DEV), .NUM_SCR_DEV(NUM_SCR_DEV), .SCR_DEPTH(SCR_DEPTH),
    .BUS_AW(BUS_AW), .BUS_DW(BUS_DW)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .idx(idx), .dev(dev),
    .wdata(ioWdata), .busReady(busReady), .busRdata(busRdata),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busLen(busLen), .devData(devData)
  );
endmodule

// File: tb/test_cfgPortBridge.sv
`timescale 1ns/1ps
module test_cfgPortBridge;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  ioAddr = 8'h00;
  logic        ioRd, ioWr;
  logic [7:0]  ioWdata = 8'h00;
  logic [7:0]  ioRdata;
  logic        busReq, busWe;
  logic [31:0] busAddr, busWdata;
  logic [2:0]  busLen;
  logic        busReady;
  logic [31:0] busRdata = 32'h0;

  int checks = 0, fails = 0;
  int respDelay = 0, waitCnt = 0;
  logic [31:0] respData = 32'h0;
  bit cmpOn = 0;

  // reference model state
  bit       mUnl, mSeen, mReq, mWe;
  byte unsigned mIdx, mDev, mLen;
  byte unsigned mScr [16];
  logic [31:0] mAddr, mData;

  always #2.5 clk = ~clk;

  cfgPortBridge i_cfgPortBridge (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .busReq(busReq), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busLen(busLen),
    .busReady(busReady), .busRdata(busRdata)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] mRd(logic [7:0] a);
    if (!mUnl) return 8'hFF;
    if (a == 8'h2E) return mIdx;
    if (a != 8'h2F) return 8'hFF;
    if (mIdx < 8'h30) return (mIdx == 8'h07) ? mDev : 8'h00;
    if (mDev == 8'h0D) begin
      if (mIdx >= 8'hF0 && mIdx <= 8'hF3) return mAddr[(3 - (mIdx - 8'hF0))*8 +: 8];
      if (mIdx >= 8'hF4 && mIdx <= 8'hF7) return mData[(3 - (mIdx - 8'hF4))*8 +: 8];
      if (mIdx == 8'hF8) return mLen;
      if (mIdx == 8'hFE) return {7'b0, mReq};
      return 8'h00;
    end
    if (mDev < 4) return mScr[mDev*4 + (mIdx & 3)];
    return 8'hFF;
  endfunction

  function automatic logic [2:0] mBusLen();
    if (mLen == 0) return 3'd1;
    if (mLen == 1) return 3'd2;
    return 3'd4;
  endfunction

  // behavioural model, updated from the same inputs at each rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mUnl = 0; mSeen = 0; mReq = 0; mWe = 0; mIdx = 0; mDev = 0; mLen = 0;
      mAddr = 0; mData = 0;
      foreach (mScr[i]) mScr[i] = 0;
    end else begin
      bit dw, dr, brg, wasReq;
      wasReq = mReq;
      dw  = mUnl && ioWr && ioAddr == 8'h2F;
      dr  = mUnl && ioRd && ioAddr == 8'h2F;
      brg = mIdx >= 8'h30 && mDev == 8'h0D;
      if (dw && mIdx == 8'h07) mDev = ioWdata;
      if (dw && mIdx >= 8'h30 && mDev < 4) mScr[mDev*4 + (mIdx & 3)] = ioWdata;
      if (dw && brg && !wasReq) begin
        if (mIdx >= 8'hF0 && mIdx <= 8'hF3) mAddr[(3 - (mIdx - 8'hF0))*8 +: 8] = ioWdata;
        if (mIdx >= 8'hF4 && mIdx <= 8'hF7) mData[(3 - (mIdx - 8'hF4))*8 +: 8] = ioWdata;
        if (mIdx == 8'hF8) mLen = ioWdata;
      end
      if (brg && mIdx == 8'hFE && !wasReq && (dw || dr)) begin
        mReq = 1; mWe = dw;
      end else if (wasReq && busReady) begin
        mReq = 0;
        if (!mWe) mData = busRdata;
      end
      if (ioWr && ioAddr == 8'h2E) begin
        if (!mUnl) begin
          if (ioWdata == 8'hA5) begin
            if (mSeen) begin mUnl = 1; mSeen = 0; end else mSeen = 1;
          end else mSeen = 0;
        end else if (ioWdata == 8'hAA) mUnl = 0;
        else mIdx = ioWdata;
      end
    end
  end

  // per-clock comparison of registered outputs against the model
  always @(negedge clk) begin
    if (cmpOn) begin
      chk("R12 busReq model", busReq, mReq);
      if (mReq) chk("R10/R11 busWe model", busWe, mWe);
      chk("R8 busAddr model", busAddr, mAddr);
      chk("R8 busWdata model", busWdata, mData);
      chk("R9 busLen model", busLen, mBusLen());
    end
  end

  // bus responder
  always @(negedge clk) begin
    if (busReady) busReady = 1'b0;
    else if (busReq) begin
      if (waitCnt >= respDelay) begin
        busReady = 1'b1; busRdata = respData; waitCnt = 0;
      end else waitCnt++;
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); ioAddr = a; ioWdata = d; ioWr = 1'b1;
    @(negedge clk); ioWr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk); ioAddr = a; ioRd = 1'b1;
    #1;
    chk(tag, ioRdata, exp);
    chk({tag, " model"}, ioRdata, mRd(a));
    @(negedge clk); ioRd = 1'b0;
  endtask

  task automatic waitIdle();
    while (busReq) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; ioRd = 1'b0; ioWr = 1'b0; busReady = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1; cmpOn = 1;
    @(negedge clk);
    chk("R1 busReq reset", busReq, 0);
    chk("R1 busLen reset", busLen, 1);
    chk("R1 busAddr reset", busAddr, 0);
    rd(8'h2F, 8'hFF, "R3 locked data read");
    rd(8'h2E, 8'hFF, "R3 locked index read");
    // broken password pair
    wr(8'h2E, 8'hA5); wr(8'h2E, 8'h00); wr(8'h2E, 8'hA5);
    rd(8'h2F, 8'hFF, "R2 broken pair stays locked");
    wr(8'h2F, 8'h11);  // data cycle must not disturb the count
    wr(8'h2E, 8'hA5);
    rd(8'h2E, 8'h00, "R1 index reset after unlock R2");
    rd(8'h44, 8'hFF, "R5 other port reads FF");
    // global area and device select
    wr(8'h2E, 8'h07); wr(8'h2F, 8'h02);
    rd(8'h2F, 8'h02, "R6 device select readback");
    rd(8'h2E, 8'h07, "R5 index readback");
    wr(8'h2E, 8'h31); wr(8'h2F, 8'h5A);
    rd(8'h2F, 8'h5A, "R7 scratch dev2");
    wr(8'h2E, 8'h33); wr(8'h2F, 8'hC3);
    rd(8'h2F, 8'hC3, "R7 scratch dev2 idx33");
    wr(8'h2E, 8'h07); wr(8'h2F, 8'h01);
    wr(8'h2E, 8'h31);
    rd(8'h2F, 8'h00, "R7 dev1 separate from dev2");
    wr(8'h2E, 8'h10); wr(8'h2F, 8'h77);
    rd(8'h2F, 8'h00, "R6 other global ignores writes");
    wr(8'h2E, 8'h07); wr(8'h2F, 8'h09);
    wr(8'h2E, 8'h31);
    rd(8'h2F, 8'hFF, "R7 unpopulated device");
    // relock and locked write
    wr(8'h2E, 8'h07);
    wr(8'h2E, 8'hAA);
    rd(8'h2F, 8'hFF, "R4 relocked");
    wr(8'h2F, 8'h33);
    wr(8'h2E, 8'h55);
    wr(8'h2E, 8'hA5);
    rd(8'h2F, 8'hFF, "R4 one password not enough");
    wr(8'h2E, 8'hA5);
    rd(8'h2E, 8'h07, "R3 index held while locked");
    rd(8'h2F, 8'h09, "R3 locked write ignored");
    // bridge registers
    wr(8'h2F, 8'h0D);
    wr(8'h2E, 8'hF0); wr(8'h2F, 8'h12);
    wr(8'h2E, 8'hF1); wr(8'h2F, 8'h34);
    wr(8'h2E, 8'hF2); wr(8'h2F, 8'h56);
    wr(8'h2E, 8'hF3); wr(8'h2F, 8'h78);
    chk("R8 busAddr MSB first", busAddr, 32'h12345678);
    wr(8'h2E, 8'hF4); wr(8'h2F, 8'hDE);
    wr(8'h2E, 8'hF5); wr(8'h2F, 8'hAD);
    wr(8'h2E, 8'hF6); wr(8'h2F, 8'hBE);
    wr(8'h2E, 8'hF7); wr(8'h2F, 8'hEF);
    chk("R8 busWdata MSB first", busWdata, 32'hDEADBEEF);
    rd(8'h2F, 8'hEF, "R8 data byte readback");
    wr(8'h2E, 8'hF8); wr(8'h2F, 8'h01);
    chk("R9 code1 two bytes", busLen, 2);
    wr(8'h2F, 8'h03);
    chk("R9 code3 four bytes", busLen, 4);
    wr(8'h2F, 8'h00);
    chk("R9 code0 one byte", busLen, 1);
    wr(8'h2F, 8'h02);
    chk("R9 code2 four bytes", busLen, 4);
    // bus write with long latency
    respDelay = 12;
    wr(8'h2E, 8'hFE); wr(8'h2F, 8'h00);
    chk("R11 write launched", busReq, 1);
    chk("R11 write direction", busWe, 1);
    wr(8'h2E, 8'hF0); wr(8'h2F, 8'hFF);
    rd(8'h2F, 8'h12, "R13 addr write ignored while busy");
    wr(8'h2E, 8'hFE);
    rd(8'h2F, 8'h01, "R10 busy flag R13 retrigger");
    chk("R13 direction kept", busWe, 1);
    waitIdle();
    chk("R12 request dropped", busReq, 0);
    chk("R12 write leaves data", busWdata, 32'hDEADBEEF);
    // bus read, short latency
    respDelay = 2; respData = 32'hCAFEF00D;
    rd(8'h2F, 8'h00, "R10 idle trigger read");
    chk("R10 read launched", busReq, 1);
    chk("R10 read direction", busWe, 0);
    waitIdle();
    chk("R12 read captured", busWdata, 32'hCAFEF00D);
    wr(8'h2E, 8'hF4);
    rd(8'h2F, 8'hCA, "R12 MSB at F4");
    wr(8'h2E, 8'hF7);
    rd(8'h2F, 8'h0D, "R12 LSB at F7");
    // bus read, zero latency
    respDelay = 0; respData = 32'h0BADC0DE;
    wr(8'h2E, 8'hFE);
    rd(8'h2F, 8'h00, "R10 second read trigger");
    waitIdle();
    @(negedge clk);
    chk("R12 fast read captured", busWdata, 32'h0BADC0DE);
    chk("R12 idle after fast read", busReq, 0);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule